// File: doc/BRIEF.md
# SDRAM Read Command Sequencer

This block sits on the controller side of an SDRAM interface. It takes read requests over a valid/ready handshake and turns each one into SDRAM commands. A request names a bank, a row, a starting column, a word count and an auto-precharge choice. The block keeps track of the open row in every bank. It closes a row with PRECHARGE when a request needs a different row. It opens rows with ACTIVE and waits out the row-to-column delay. It then issues one READ per word on consecutive cycles, with the column rising by one each time.

The SDRAM is assumed to be set up for a burst length of one, so each READ returns exactly one word, CL cycles later. The block registers every returned word and presents it on `rd_data` with `rd_valid`. A request that hits a row that is already open is accepted on the cycle of the previous request's final READ. Its first READ then follows on the next cycle, so the returned words arrive with no gap. The ACTIVE-to-READ delay (`cfg_trcd`) and the CAS latency (`cfg_cl`, 2 or 3) are runtime inputs. They must stay stable while requests are in flight.

Top module: `sdram_rd_seq`

## Requirements
- R1: After reset the command output is NOP, `rd_valid` is low, `req_ready` is high and every bank is treated as closed.
- R2: The first READ after an ACTIVE is issued exactly max(`cfg_trcd`,1) cycles after the ACTIVE, with NOPs in between; for a delay of 3 that is two NOP cycles.
- R3: Every READ issued in cycle k gives one `rd_valid` cycle at k+CL+1, carrying the value of `dq_in` in cycle k+CL. The total number of valid words equals the sum of the requested lengths, with a length of 0 counted as 1.
- R4: A request of length L produces L READs on consecutive cycles to its bank, at columns col, col+1, ... col+L-1. The column sits in address bits [COL_W-1:0].
- R5: A request to a bank whose open row differs first gets a PRECHARGE to that bank with address bit 10 low. ACTIVE is issued only to a closed bank, and no earlier than TRP cycles after the most recent PRECHARGE.
- R6: A request that hits an open row, in any bank, and is presented during the current request's final READ has its first READ on the very next cycle, so `rd_valid` stays high across both requests.
- R7: With auto precharge selected, address bit 10 is high on the request's final READ only. The bank is then closed, and the next ACTIVE comes no earlier than TRP+CL+1 cycles after that READ.
- R8: Commands use the encoding {ras_n,cas_n,we_n}: NOP 3'b111, ACTIVE 3'b011, READ 3'b101, PRECHARGE 3'b010. ACTIVE carries the row on `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 3 | Minimum ACTIVE-to-READ delay in cycles (0 treated as 1) |
| cfg_cl | input | 2 | CAS latency, 2 or 3 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_bank | input | BA_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Word count (0 treated as 1) |
| req_ap | input | 1 | Auto precharge after the final word |
| cmd | output | 3 | {ras_n,cas_n,we_n} command |
| cmd_ba | output | BA_W | Command bank |
| cmd_addr | output | ROW_W | Command address (row, or column plus bit 10) |
| dq_in | input | DQ_W | Data returned by the SDRAM |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DQ_W | Read word |

## Verification
The bench sweeps every combination of CAS latency, row delay 0 to 3 and length 1 to 4. It drives a mix of row hits, misses against an open row, misses against a closed bank and auto-precharge requests. A behavioural memory returns words that encode bank, row and column. A design that reads the wrong row, skips a PRECHARGE, or lets auto precharge close the row too early therefore returns wrong data or reads a closed bank. The bench measures the ACTIVE-to-READ gap, the READ-to-data latency and the PRECHARGE/auto-precharge recovery against arithmetic expectations. It checks that chained hits produce an unbroken valid run, which catches an extra cycle or a missed same-cycle acceptance. A closed bank that is wrongly seen as still open, because the final auto-precharge READ and the next acceptance share a cycle, shows up as a read to a closed bank.

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int LEN_W  = 4,
  parameter int DQ_W   = 16,
  parameter int TRP    = 2,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS),
  localparam int WC_W  = $clog2(TRP + 4) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_trcd,
  input  logic [1:0]       cfg_cl,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_ap,
  output logic [2:0]       cmd,
  output logic [BA_W-1:0]  cmd_ba,
  output logic [ROW_W-1:0] cmd_addr,
  input  logic [DQ_W-1:0]  dq_in,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data
);
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_PRE = 3'b010;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_TRCD, S_RD} st_t;

  st_t              st;
  logic [BA_W-1:0]  c_ba;
  logic [ROW_W-1:0] c_row;
  logic [COL_W-1:0] c_col;
  logic [LEN_W-1:0] c_rem;
  logic             c_ap;
  logic [BANKS-1:0] open_v;
  logic [ROW_W-1:0] open_row [BANKS];
  logic [WC_W-1:0]  wcnt;
  logic [2:0]       tcnt;
  logic [2:0]       pipe;

  wire [2:0] trcd_e  = (cfg_trcd == 3'd0) ? 3'd1 : cfg_trcd;
  wire       last    = (st == S_RD) && (c_rem == LEN_W'(1));
  wire       closing = last && c_ap;
  wire       take    = req_valid && req_ready;
  wire       hit_open = open_v[req_bank] && !(closing && req_bank == c_ba);
  wire       row_eq  = open_row[req_bank] == req_row;
  wire       act_go  = (st == S_ACT) && (wcnt == '0);

  assign req_ready = (st == S_IDLE) || last;
  assign cmd_ba    = c_ba;

  always_comb begin
    cmd      = C_NOP;
    cmd_addr = '0;
    case (st)
      S_PRE: cmd = C_PRE;
      S_ACT: if (act_go) begin
        cmd      = C_ACT;
        cmd_addr = c_row;
      end
      S_RD: begin
        cmd                  = C_RD;
        cmd_addr[COL_W-1:0]  = c_col;
        cmd_addr[AP_BIT]     = closing;
      end
      default: ;
    endcase
  end

  logic [WC_W-1:0] w_dec, w_load;
  logic            w_do;
  always_comb begin
    w_dec  = (wcnt == '0) ? '0 : wcnt - 1'b1;
    w_do   = 1'b0;
    w_load = '0;
    if (st == S_PRE) begin
      w_do   = 1'b1;
      w_load = WC_W'(TRP - 1);
    end else if (closing) begin
      w_do   = 1'b1;
      w_load = WC_W'(TRP) + WC_W'(cfg_cl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      c_ba   <= '0;
      c_row  <= '0;
      c_col  <= '0;
      c_rem  <= '0;
      c_ap   <= 1'b0;
      open_v <= '0;
      wcnt   <= '0;
      tcnt   <= '0;
      for (int i = 0; i < BANKS; i++) open_row[i] <= '0;
    end else begin
      wcnt <= (w_do && w_load > w_dec) ? w_load : w_dec;
      case (st)
        S_PRE: begin
          open_v[c_ba] <= 1'b0;
          st           <= S_ACT;
        end
        S_ACT: if (act_go) begin
          open_v[c_ba]   <= 1'b1;
          open_row[c_ba] <= c_row;
          tcnt           <= trcd_e - 3'd1;
          st             <= (trcd_e == 3'd1) ? S_RD : S_TRCD;
        end
        S_TRCD: begin
          tcnt <= tcnt - 3'd1;
          if (tcnt == 3'd1) st <= S_RD;
        end
        S_RD: begin
          c_col <= c_col + 1'b1;
          c_rem <= c_rem - 1'b1;
          if (closing) open_v[c_ba] <= 1'b0;
          if (last && !take) st <= S_IDLE;
        end
        default: ;
      endcase
      if (take) begin
        c_ba  <= req_bank;
        c_row <= req_row;
        c_col <= req_col;
        c_rem <= (req_len == '0) ? LEN_W'(1) : req_len;
        c_ap  <= req_ap;
        st    <= (hit_open && row_eq) ? S_RD : (hit_open ? S_PRE : S_ACT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[1:0], cmd == C_RD};
      rd_valid <= (cfg_cl == 2'd3) ? pipe[2] : pipe[1];
      rd_data  <= dq_in;
    end
  end

  logic [3:0]      since_act, since_pre;
  logic [BA_W-1:0] act_ba;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      act_ba    <= '0;
    end else begin
      since_act <= (cmd == C_ACT) ? 4'd1 : ((since_act == '1) ? since_act : since_act + 4'd1);
      since_pre <= (cmd == C_PRE) ? 4'd1 : ((since_pre == '1) ? since_pre : since_pre + 4'd1);
      if (cmd == C_ACT) act_ba <= cmd_ba;
    end
  end

  AST_TRCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && act_ba == cmd_ba) |-> since_act >= {1'b0, trcd_e}); // R2
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> since_pre >= 4'(TRP)); // R5
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> !open_v[cmd_ba]); // R5
  AST_LAT_CL2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cfg_cl == 2'd2) |-> $past(cmd == C_RD, 3)); // R3
  AST_LAT_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cfg_cl == 2'd3) |-> $past(cmd == C_RD, 4)); // R3
endmodule

// File: tb/tb_sdram_rd_seq.sv
`timescale 1ns/1ps
module tb_sdram_rd_seq;
  localparam int TRP = 2;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_PRE = 3'b010;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  cfg_trcd = 3'd2;
  logic [1:0]  cfg_cl = 2'd2;
  logic        req_valid = 0, req_ready, req_ap = 0;
  logic [1:0]  req_bank = 0;
  logic [11:0] req_row = 0;
  logic [8:0]  req_col = 0;
  logic [3:0]  req_len = 1;
  logic [2:0]  cmd;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_addr;
  logic [15:0] dq_in, rd_data;
  logic        rd_valid;

  always #2.5 clk = ~clk;

  sdram_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
    .cmd(cmd), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data));

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
    return {b, r[4:0], c};
  endfunction

  logic [15:0] expq [8192];
  int wp = 0, rp = 0, exp_ap = 0, ap_cnt = 0;
  int cyc = 0;
  int first_c = 0, last_c = 0, vcnt = 0;

  logic [15:0] m_d [4];
  bit          mopen [4];
  logic [11:0] mrow [4];
  int          pre_cyc [4], ap_cyc [4];
  int          act_cyc = 0, act_bk = 0;
  bit          pend_first = 0;
  int          st_ring [16];
  int          sw = 0, sr = 0;
  logic [2:0]  prev_cmd = C_NOP;
  logic        prev_v = 0;

  assign dq_in = m_d[cfg_cl];

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_d[i] = 0; mopen[i] = 0; mrow[i] = 0; pre_cyc[i] = -100; ap_cyc[i] = -100;
    end
  end

  always @(negedge clk) if (rst_n) begin
    int te;
    te = (cfg_trcd == 0) ? 1 : int'(cfg_trcd);
    cyc++;
    for (int j = 3; j > 0; j--) m_d[j] = m_d[j-1];
    m_d[0] = 16'h0;
    if (cmd == C_RD) begin
      chk(mopen[cmd_ba], "R4 R7 read to closed bank", 0, 1);
      m_d[0] = mopen[cmd_ba] ? wd(cmd_ba, mrow[cmd_ba], cmd_addr[8:0]) : 16'hDEAD;
      if (pend_first && int'(cmd_ba) == act_bk) begin
        chk(cyc - act_cyc == te, "R2 act-to-read gap", cyc - act_cyc, te);
        pend_first = 0;
      end
      if (prev_cmd != C_RD) begin st_ring[sw % 16] = cyc; sw++; end
      if (cmd_addr[10]) begin mopen[cmd_ba] = 0; ap_cyc[cmd_ba] = cyc; ap_cnt++; end
    end else if (cmd == C_ACT) begin
      chk(!mopen[cmd_ba], "R5 activate open bank", 1, 0);
      chk(cyc - pre_cyc[cmd_ba] >= TRP, "R5 precharge recovery", cyc - pre_cyc[cmd_ba], TRP);
      chk(cyc - ap_cyc[cmd_ba] >= TRP + int'(cfg_cl) + 1, "R7 auto precharge recovery",
          cyc - ap_cyc[cmd_ba], TRP + int'(cfg_cl) + 1);
      mopen[cmd_ba] = 1; mrow[cmd_ba] = cmd_addr;
      act_cyc = cyc; act_bk = int'(cmd_ba); pend_first = 1;
    end else if (cmd == C_PRE) begin
      chk(cmd_addr[10] == 1'b0, "R5 single-bank precharge", int'(cmd_addr[10]), 0);
      mopen[cmd_ba] = 0; pre_cyc[cmd_ba] = cyc;
    end else begin
      chk(cmd == C_NOP, "R8 command encoding", int'(cmd), int'(C_NOP));
    end
    if (rd_valid) begin
      if (!prev_v) begin
        chk(sr < sw && cyc - st_ring[sr % 16] == int'(cfg_cl) + 1, "R3 read latency",
            cyc - st_ring[sr % 16], int'(cfg_cl) + 1);
        sr++;
      end
      chk(rp < wp, "R3 extra word", rp, wp);
      if (rp < wp) begin
        chk(rd_data == expq[rp], "R4 word value", int'(rd_data), int'(expq[rp]));
        rp++;
      end
      if (vcnt == 0) first_c = cyc;
      last_c = cyc;
      vcnt++;
    end
    prev_cmd = cmd;
    prev_v = rd_valid;
  end

  task automatic send(input int b, input int r, input int c, input int len, input bit ap);
    req_bank = 2'(b); req_row = 12'(r); req_col = 9'(c); req_len = 4'(len); req_ap = ap;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int i = 0; i < ((len == 0) ? 1 : len); i++) begin
      expq[wp] = wd(2'(b), 12'(r), 9'(c + i));
      wp++;
    end
    if (ap) exp_ap++;
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = 0;
    repeat (30) @(negedge clk);
    chk(rp == wp, "R3 word count", rp, wp);
    chk(ap_cnt == exp_ap, "R7 auto precharge count", ap_cnt, exp_ap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd == C_NOP, "R1 R8 reset command", int'(cmd), int'(C_NOP));
    chk(rd_valid == 0, "R1 reset valid", int'(rd_valid), 0);
    chk(req_ready == 1, "R1 reset ready", int'(req_ready), 1);
    send(2, 5, 0, 1, 0);
    drain();
    for (int cl = 2; cl <= 3; cl++)
      for (int t = 0; t <= 3; t++)
        for (int len = 1; len <= 4; len++) begin
          int r;
          r = 2 * ((cl - 2) * 16 + t * 4 + len);
          cfg_cl = 2'(cl); cfg_trcd = 3'(t);
          @(negedge clk);
          send(0, r, 0, len, 0);
          send(0, r, 16, len, 0);
          send(1, r + 1, 32, len, 0);
          send(1, r + 1, 48, len, 1);
          send(1, r + 1, 64, len, 0);
          send(0, r + 1, 80, len, 0);
          drain();
          vcnt = 0;
          send(0, r + 1, 96, len, 0);
          send(1, r + 1, 112, len, 0);
          drain();
          chk(vcnt == 2 * len, "R6 chained word count", vcnt, 2 * len);
          chk(last_c - first_c + 1 == vcnt, "R6 gapless chain", last_c - first_c + 1, vcnt);
        end
    send(3, 7, 500, 0, 0);
    drain();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule